// File: doc/BRIEF.md
# Programmable Interrupt Vector Controller

This block gathers interrupt requests from sixteen device lines and one internal error line. Each request is captured in a sticky pending bit, so a request lasting a single clock is kept. Every source has its own vector register that software can write, and an enable mask decides which pending sources may compete. A fixed priority picks one winner among the enabled pending sources. The error line always wins. Among devices, a lower index wins. A single interrupt output tells the processor side that work is waiting.

Software services the interrupt by reading an identification address. That read returns the winning source's vector, and the same clock edge clears that source's pending bit. No other acknowledge is needed. If nothing enabled is pending, the read returns zero. A small state machine drives the interrupt output. It has three states. IDLE means no enabled source is pending. RAISED means the output is high. ACKED is a one-cycle gap after every identification read that found a winner. The transitions are: IDLE to RAISED when an enabled source is pending; RAISED to IDLE when none remains (for example after the mask changes); IDLE or RAISED to ACKED on a successful identification read; ACKED to ACKED on another successful read; ACKED to RAISED or to IDLE, depending on whether any enabled source is still pending.

Source numbering: devices are sources 0 to 15 and the error line is source 16. Address map (default parameters): 0 to 15 hold the device vectors, 16 holds the error vector, 17 holds the enable mask, and 18 is the identification address.

Top module: `intvec_ctrl`

## Requirements
- R1: After reset, `irq` is low, every vector register and the enable mask read as zero, and nothing is pending.
- R2: Writing address s (0 to 15 for device s, 16 for the error source) stores `wdata[7:0]` as that source's vector. A read of the address returns it zero-extended on `rdata` one cycle after `rd_en`.
- R3: Address 17 holds the enable mask. Bit s (bits 0 to 15 for devices, bit 16 for the error source) set to 1 enables source s. It reads back as written in bits [16:0].
- R4: A request held high for one clock sets that source's pending bit. The bit stays set until an identification read selects that source.
- R5: A masked source still latches its request but is never selected and never raises `irq`. Once it is enabled, it is served.
- R6: Priority among enabled pending sources: the error source first, then device 0, device 1, and so on up to device 15.
- R7: `irq` goes high on the second clock edge after a request edge when that source is enabled, or on the second edge after a mask write that enables an already pending source. It stays high while any enabled source is pending.
- R8: A read of address 18 returns the winning source's vector one cycle later and clears only that source's pending bit, on the same edge.
- R9: A read of address 18 with no enabled source pending returns zero and changes nothing.
- R10: After a successful identification read, `irq` is low for exactly one cycle (state ACKED). It then returns high if another enabled source is pending.
- R11: If a source's request is still high on the edge where its pending bit is cleared, the bit stays set.
- R12: Writes to address 18 and to unmapped addresses (19 to 31) change no vector, mask or pending state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dev_req | input | 16 | Device request lines, bit s is device s |
| err_req | input | 1 | Internal error request line |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 5 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after `rd_en` |
| irq | output | 1 | Interrupt request to the processor side |

## Verification
Read data, including the identification vector, appears one cycle after the read strobe. The scoreboard records each read's expected value when it issues the read, and the monitor compares `rdata` at the following falling edge. `irq` rises two edges after a request or enabling write and falls one edge after a successful identification read. The bench checks it at the falling edge that follows exactly that count, and again one cycle later to confirm the one-cycle gap or the steady level. Priority and clear-only-the-winner are checked by latching several sources in one cycle and draining them through consecutive identification reads whose order is fixed in advance.

// File: rtl/intvec_pkg.sv
package intvec_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RAISED = 2'd1,
        ST_ACKED  = 2'd2
    } irq_state_e;

endpackage

// File: rtl/intvec_latch.sv
module intvec_latch #(
    parameter int NUM_SRC = 17
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] req,
    input  logic [NUM_SRC-1:0] clr,
    output logic [NUM_SRC-1:0] pend
);

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_bit
        logic bit_q;
        // a live request on the clearing edge keeps the bit set
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) bit_q <= 1'b0;
            else        bit_q <= (bit_q & ~clr[g]) | req[g];
        end
        assign pend[g] = bit_q;
    end

endmodule

// File: rtl/intvec_prio.sv
module intvec_prio #(
    parameter int NUM_DEV = 16,
    localparam int NUM_SRC = NUM_DEV + 1,
    localparam int IDX_W = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0] cand,
    output logic               win_valid,
    output logic [IDX_W-1:0]   win_idx
);

    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        // lowest priority first, so later hits override
        for (int i = NUM_DEV - 1; i >= 0; i--) begin
            if (cand[i]) begin
                win_valid = 1'b1;
                win_idx   = IDX_W'(i);
            end
        end
        if (cand[NUM_DEV]) begin
            win_valid = 1'b1;
            win_idx   = IDX_W'(NUM_DEV);
        end
    end

endmodule

// File: rtl/intvec_regs.sv
module intvec_regs #(
    parameter int NUM_DEV = 16,
    parameter int VEC_W   = 8,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 5,
    localparam int NUM_SRC = NUM_DEV + 1,
    localparam int IDX_W = $clog2(NUM_SRC),
    localparam int MASK_ADDR = NUM_DEV + 1,
    localparam int ID_ADDR = NUM_DEV + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    input  logic               win_valid,
    input  logic [IDX_W-1:0]   win_idx,
    output logic [NUM_SRC-1:0] mask,
    output logic [DATA_W-1:0]  rdata
);

    logic [VEC_W-1:0]   vec_q [NUM_SRC];
    logic [NUM_SRC-1:0] mask_q;
    logic [DATA_W-1:0]  rdata_q;
    logic               unused_wdata;

    assign unused_wdata = ^wdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < NUM_SRC; s++) vec_q[s] <= '0;
            mask_q <= '0;
        end else if (wr_en) begin
            if (int'(addr) < NUM_SRC)
                vec_q[addr] <= wdata[VEC_W-1:0];
            else if (int'(addr) == MASK_ADDR)
                mask_q <= wdata[NUM_SRC-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_en) begin
            if (int'(addr) < NUM_SRC)
                rdata_q <= DATA_W'(vec_q[addr]);
            else if (int'(addr) == MASK_ADDR)
                rdata_q <= DATA_W'(mask_q);
            else if (int'(addr) == ID_ADDR)
                rdata_q <= win_valid ? DATA_W'(vec_q[win_idx]) : '0;
            else
                rdata_q <= '0;
        end
    end

    assign mask  = mask_q;
    assign rdata = rdata_q;

endmodule

// File: rtl/intvec_fsm.sv
module intvec_fsm
    import intvec_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic any_cand,
    input  logic id_ack,
    output logic irq
);

    irq_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = id_ack ? ST_ACKED : (any_cand ? ST_RAISED : ST_IDLE);
            ST_RAISED: state_d = id_ack ? ST_ACKED : (any_cand ? ST_RAISED : ST_IDLE);
            ST_ACKED:  state_d = id_ack ? ST_ACKED : (any_cand ? ST_RAISED : ST_IDLE);
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_RAISED: irq = 1'b1;
            default:   irq = 1'b0;
        endcase
    end

endmodule

// File: rtl/intvec_ctrl.sv
module intvec_ctrl #(
    parameter int NUM_DEV = 16,
    parameter int VEC_W   = 8,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = $clog2(NUM_DEV + 3)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_DEV-1:0] dev_req,
    input  logic               err_req,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    output logic               irq
);

    localparam int NUM_SRC = NUM_DEV + 1;
    localparam int IDX_W   = $clog2(NUM_SRC);
    localparam int ID_ADDR = NUM_DEV + 2;

    logic [NUM_SRC-1:0] src_req, pend_q, mask, cand, clr;
    logic               win_valid, any_cand, id_ack;
    logic [IDX_W-1:0]   win_idx;

    assign src_req  = {err_req, dev_req};
    assign cand     = pend_q & mask;
    assign any_cand = |cand;
    assign id_ack   = rd_en && (addr == ADDR_W'(ID_ADDR)) && win_valid;

    always_comb begin
        clr = '0;
        if (id_ack) clr[win_idx] = 1'b1;
    end

    intvec_latch #(.NUM_SRC(NUM_SRC)) u_latch (
        .clk(clk), .rst_n(rst_n), .req(src_req), .clr(clr), .pend(pend_q)
    );

    intvec_prio #(.NUM_DEV(NUM_DEV)) u_prio (
        .cand(cand), .win_valid(win_valid), .win_idx(win_idx)
    );

    intvec_regs #(.NUM_DEV(NUM_DEV), .VEC_W(VEC_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .win_valid(win_valid), .win_idx(win_idx),
        .mask(mask), .rdata(rdata)
    );

    intvec_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .any_cand(any_cand), .id_ack(id_ack), .irq(irq)
    );

endmodule

// File: rtl/intvec_ctrl_chk.sv
module intvec_ctrl_chk #(
    parameter int NUM_SRC = 17,
    parameter int ADDR_W  = 5,
    parameter int DATA_W  = 32,
    parameter int ID_ADDR = 18
) (
    input logic               clk,
    input logic               rst_n,
    input logic               irq,
    input logic               rd_en,
    input logic [ADDR_W-1:0]  addr,
    input logic [DATA_W-1:0]  rdata,
    input logic [NUM_SRC-1:0] src_req,
    input logic [NUM_SRC-1:0] pend,
    input logic [NUM_SRC-1:0] mask,
    input logic [NUM_SRC-1:0] clr,
    input logic               id_ack
);

    logic seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!irq && pend == '0));

    a_r4_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> (($past(pend) & ~$past(clr) & ~pend) == '0));

    a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> ((pend & $past(src_req)) == $past(src_req)));

    a_r8_single_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clr) && ((clr != '0) -> id_ack));

    a_r5_masked_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (clr & ~mask) == '0);

    a_r7_irq_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && irq) |-> $past((pend & mask) != '0));

    a_r10_ack_gap: assert property (@(posedge clk) disable iff (!rst_n)
        id_ack |=> !irq);

    a_r9_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_W'(ID_ADDR) && (pend & mask) == '0) |=> rdata == '0);

endmodule

bind intvec_ctrl intvec_ctrl_chk #(
    .NUM_SRC(NUM_DEV + 1), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_ADDR(NUM_DEV + 2)
) u_chk (
    .clk(clk), .rst_n(rst_n), .irq(irq), .rd_en(rd_en), .addr(addr), .rdata(rdata),
    .src_req(src_req), .pend(pend_q), .mask(mask), .clr(clr), .id_ack(id_ack)
);

// File: tb/sim_intvec_ctrl.sv
`timescale 1ns/1ps
module sim_intvec_ctrl;

    localparam int ID  = 18;
    localparam int MSK = 17;
    localparam int ERR = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] dev_req = '0;
    logic        err_req = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0, failures = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        issued = 1'b0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    intvec_ctrl u0 (.clk(clk), .rst_n(rst_n), .dev_req(dev_req), .err_req(err_req),
                    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
                    .rdata(rdata), .irq(irq));

    // monitor: a read issued at one edge is compared at the next falling edge
    always @(posedge clk) issued <= rd_en;
    always @(negedge clk) begin
        if (issued && exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (rdata !== e) begin
                failures++;
                $display("FAIL %s rdata actual=%h expected=%h", t, rdata, e);
            end
        end
    end

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = 5'(a); wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, input logic [31:0] e, input string t);
        @(negedge clk);
        rd_en = 1'b1; addr = 5'(a);
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic pulse(input logic [15:0] d, input logic e);
        @(negedge clk);
        dev_req = d; err_req = e;
        @(negedge clk);
        dev_req = '0; err_req = 1'b0;
    endtask

    task automatic chk_irq(input logic e, input string t);
        checks++;
        if (irq !== e) begin
            failures++;
            $display("FAIL %s irq actual=%b expected=%b", t, irq, e);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk_irq(1'b0, "R1 irq after reset");
        rd(0, 32'h0, "R1 vector 0 reset");
        rd(MSK, 32'h0, "R1 mask reset");
        rd(ID, 32'h0, "R1/R9 ident empty");

        // R2 vector programming
        for (int s = 0; s < 16; s++) wr(s, 32'h40 + s);
        wr(ERR, 32'hFFFF_FFE0);
        rd(5, 32'h45, "R2 device 5 vector");
        rd(15, 32'h4F, "R2 device 15 vector");
        rd(ERR, 32'hE0, "R2 error vector zero-extended");
        wr(3, 32'h1234_56AB);
        rd(3, 32'hAB, "R2 only low bits kept");
        wr(3, 32'h43);

        // R12 ignored writes
        wr(ID, 32'hFFFF_FFFF);
        wr(25, 32'hFFFF_FFFF);
        rd(MSK, 32'h0, "R12 mask unchanged");
        rd(ERR, 32'hE0, "R12 error vector unchanged");
        rd(ID, 32'h0, "R12 ident still empty");
        chk_irq(1'b0, "R12 irq stays low");

        // R5 masked source latches but stays silent
        pulse(16'h0004, 1'b0);
        repeat (3) @(negedge clk);
        chk_irq(1'b0, "R5 masked no irq");
        rd(ID, 32'h0, "R5 masked not selected");
        wr(MSK, 32'h0001_FFFF);
        chk_irq(1'b0, "R7 irq not yet after mask write");
        @(negedge clk);
        chk_irq(1'b1, "R5/R7 irq after enabling pending source");
        rd(MSK, 32'h0001_FFFF, "R3 mask readback");
        rd(ID, 32'h42, "R8 ident device 2");
        chk_irq(1'b0, "R10 gap after ident");
        @(negedge clk);
        chk_irq(1'b0, "R8 nothing left pending");
        rd(ID, 32'h0, "R9 ident after drain");

        // R7 timing from a one-cycle request
        @(negedge clk);
        dev_req = 16'h0080;
        @(negedge clk);
        dev_req = '0;
        chk_irq(1'b0, "R7 irq low one edge after request");
        @(negedge clk);
        chk_irq(1'b1, "R4/R7 irq high two edges after pulse");
        rd(ID, 32'h47, "R4 ident device 7");

        // R6 priority drain
        pulse(16'h1210, 1'b1);
        repeat (2) @(negedge clk);
        chk_irq(1'b1, "R6 irq with four pending");
        rd(ID, 32'hE0, "R6 error first");
        chk_irq(1'b0, "R10 gap after error ack");
        @(negedge clk);
        chk_irq(1'b1, "R10 irq returns with more pending");
        rd(ID, 32'h44, "R6 device 4 second");
        rd(ID, 32'h49, "R6 device 9 third");
        rd(ID, 32'h4C, "R6 device 12 fourth");
        rd(ID, 32'h0, "R8 all cleared");

        // R11 request held across clearing edge
        @(negedge clk);
        dev_req = 16'h0002;
        repeat (2) @(negedge clk);
        rd(ID, 32'h41, "R11 first ident device 1");
        rd(ID, 32'h41, "R11 relatched while high");
        dev_req = '0;
        rd(ID, 32'h41, "R11 last latched copy");
        rd(ID, 32'h0, "R11 cleared after release");

        // R3/R5 selective mask
        wr(MSK, 32'h0000_0001);
        pulse(16'h0001, 1'b1);
        repeat (2) @(negedge clk);
        rd(MSK, 32'h0000_0001, "R3 partial mask readback");
        rd(ID, 32'h40, "R5 enabled device 0 served");
        rd(ID, 32'h0, "R5 masked error ignored");
        @(negedge clk);
        chk_irq(1'b0, "R5 masked error silent");
        wr(MSK, 32'h0001_0000);
        @(negedge clk);
        chk_irq(1'b1, "R5 error served once enabled");
        rd(ID, 32'hE0, "R5 error vector after enable");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule